// File: doc/BRIEF.md
# Low-Power Counter with Compare Channels

A 24-bit timekeeping counter that runs in a slow clock domain. It advances once per clock while enabled, carries two compare registers, and can use compare register 0 as its wrap value in place of the all-ones maximum. The overflow event and each compare hit latch a flag. The flags are masked by an interrupt-enable register and merged into one interrupt line. A debug-halt input can stop the count, and a debug-run control bit overrides that stop.

Software drives a small register window that is synchronous to the same clock. The control, compare, interrupt-enable and freeze registers are written through it, and the flags and the live count are read through it. While the freeze bit is set, writes to control and compare are held in staging copies. All of them take effect together on the write that clears freeze. Moving data across clock domains happens outside this block.

Top module: `lp_compare_counter`

## Requirements
- R1: After reset, every readable register (control, interrupt enable, flags, freeze, both compares) reads 0, `count` is 0 and `irq` is low.
- R2: Control register (address 0) bit 0 is enable. While it is set, the counter rises by one per clock. While it is clear, the counter is held at 0, so clearing and then setting enable restarts the count from zero.
- R3: With control bit 2 clear, the counter wraps from all ones to 0, and on that clock flag bit 0 (overflow) sets.
- R4: With control bit 2 set, the counter wraps to 0 on the clock after it holds the compare-0 value, and on that clock flag bit 0 sets.
- R5: Flag bit 1 sets on a counting clock whose starting count equals compare 0. Flag bit 2 does the same for compare 1. Flags stay set until cleared.
- R6: While `dbg_halt` is high, the count holds if control bit 1 (debug-run) is clear, and it keeps advancing if bit 1 is set.
- R7: A write to address 2 clears each flag whose data bit is 1 and leaves the other flags unchanged. A read of address 2 returns the flags as {cmp1, cmp0, overflow}.
- R8: `irq` is high exactly when some flag is set together with its bit in the interrupt-enable register (address 1).
- R9: Compares live at addresses 4+index. Index 0 and 1 are real. Index 2 and 3 (addresses 6, 7) read 0 and ignore writes, and such writes leave both real compares unchanged.
- R10: While freeze (address 3, bit 0) is set, writes to control and the compares are staged, and reads return the staged values, but counting uses the old values. Writing freeze to 0 applies all staged values at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock, one count tick per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_halt | input | 1 | Debug halt request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | ADDR_W | Read address (8 returns the count) |
| rd_data | output | CNT_W | Read data, combinational |
| count | output | CNT_W | Live counter value |
| irq | output | 1 | Masked interrupt |

## Verification
A table of vectors runs the counter from a cleared state under different top-mode settings and compare placements. Each vector is compared against a tick-by-tick model computed in the bench. The vectors separate a compare hit before the wrap from one after it, a zero top that wraps on every tick, and compares that are never reached. Directed cases follow. Debug halt is tried with and without debug-run. Enable is dropped and restored to show the restart from zero. A narrow instance runs to just below and just past the natural wrap. A freeze sequence shows that staged writes have no effect until release. Further cases cover the unused compare slots and clearing one flag at a time under different interrupt masks.

// File: rtl/lp_compare_counter.sv
module lp_compare_counter #(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_halt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              irq
);
  localparam int NCMP    = 2;
  localparam int CTL_W   = 3;
  localparam int FLG_W   = NCMP + 1;
  localparam int A_CTRL  = 0;
  localparam int A_IEN   = 1;
  localparam int A_FLAG  = 2;
  localparam int A_FRZ   = 3;
  localparam int A_CMP   = 4;
  localparam int A_CNT   = 8;

  logic [CTL_W-1:0] ctrl_q, ctrl_s;
  logic [CNT_W-1:0] cmp_q [NCMP];
  logic [CNT_W-1:0] cmp_s [NCMP];
  logic [FLG_W-1:0] ien_q, flg_q, flg_set, flg_clr;
  logic             frz_q;
  logic [CNT_W-1:0] cnt_q, top;
  logic             w_ctrl, w_ien, w_flag, w_frz, release_frz, run, at_top;
  logic [NCMP-1:0]  w_cmp;

  assign w_ctrl      = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign w_ien       = wr_en && (wr_addr == ADDR_W'(A_IEN));
  assign w_flag      = wr_en && (wr_addr == ADDR_W'(A_FLAG));
  assign w_frz       = wr_en && (wr_addr == ADDR_W'(A_FRZ));
  assign release_frz = frz_q && w_frz && !wr_data[0];

  assign run    = ctrl_q[0] && (!dbg_halt || ctrl_q[1]);
  assign top    = ctrl_q[2] ? cmp_q[0] : {CNT_W{1'b1}};
  assign at_top = (cnt_q == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_s <= '0;
      ctrl_q <= '0;
    end else begin
      if (w_ctrl) ctrl_s <= wr_data[CTL_W-1:0];
      if (w_ctrl && !frz_q) ctrl_q <= wr_data[CTL_W-1:0];
      else if (release_frz) ctrl_q <= ctrl_s;
    end
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    assign w_cmp[k] = wr_en && (wr_addr == ADDR_W'(A_CMP + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_s[k] <= '0;
        cmp_q[k] <= '0;
      end else begin
        if (w_cmp[k]) cmp_s[k] <= wr_data;
        if (w_cmp[k] && !frz_q) cmp_q[k] <= wr_data;
        else if (release_frz) cmp_q[k] <= cmp_s[k];
      end
    end
    assign flg_set[k+1] = run && (cnt_q == cmp_q[k]);
  end

  assign flg_set[0] = run && at_top;
  assign flg_clr    = w_flag ? wr_data[FLG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flg_q <= '0;
      ien_q <= '0;
      frz_q <= 1'b0;
    end else begin
      if (!ctrl_q[0])  cnt_q <= '0;
      else if (run)    cnt_q <= at_top ? '0 : cnt_q + 1'b1;
      flg_q <= (flg_q & ~flg_clr) | flg_set;
      if (w_ien) ien_q <= wr_data[FLG_W-1:0];
      if (w_frz) frz_q <= wr_data[0];
    end
  end

  assign count = cnt_q;
  assign irq   = |(flg_q & ien_q);

  always_comb begin
    rd_data = '0;
    case (int'(rd_addr))
      A_CTRL:    rd_data[CTL_W-1:0] = ctrl_s;
      A_IEN:     rd_data[FLG_W-1:0] = ien_q;
      A_FLAG:    rd_data[FLG_W-1:0] = flg_q;
      A_FRZ:     rd_data[0]         = frz_q;
      A_CMP:     rd_data            = cmp_s[0];
      A_CMP + 1: rd_data            = cmp_s[1];
      A_CNT:     rd_data            = cnt_q;
      default:   rd_data            = '0;
    endcase
  end

  p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |=> (cnt_q == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_top) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && at_top) |=> ((cnt_q == '0) && flg_q[0]));

  p_cmp1_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cnt_q == cmp_q[1])) |=> flg_q[2]);

  p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !ctrl_q[1]) |=> ($stable(cnt_q) || (cnt_q == '0)));

  p_quiet_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && !w_frz) |=> ($stable(ctrl_q) && $stable(cmp_q[0]) && $stable(cmp_q[1])));
endmodule

// File: tb/lp_compare_counter_test.sv
`timescale 1ns/100ps
module lp_compare_counter_test;
  logic        clk = 0, rst_n = 0, dbg_halt = 0, wr_en = 0;
  logic [3:0]  wr_addr = 0, rd_addr = 0;
  logic [23:0] wr_data = 0, rd_data, count;
  logic        irq;
  logic [7:0]  s_rd_data, s_count;
  logic        s_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lp_compare_counter uut (.clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .count(count), .irq(irq));

  lp_compare_counter #(.CNT_W(8)) uut_small (.clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data[7:0]), .rd_addr(rd_addr),
    .rd_data(s_rd_data), .count(s_count), .irq(s_irq));

  localparam int NV = 5;
  localparam int V_TOP [NV] = '{0, 1, 1, 0, 1};
  localparam int V_C0  [NV] = '{3, 4, 0, 100, 6};
  localparam int V_C1  [NV] = '{7, 2, 9, 10, 6};
  localparam int V_N   [NV] = '{5, 7, 3, 20, 15};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(a); wr_data = 24'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [23:0] v);
    rd_addr = 4'(a);
    #0.3;
    v = rd_data;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model(input int tsel, input int c0, input int c1, input int n,
                       output int cnt, output int flg);
    int tp;
    cnt = 0; flg = 0;
    tp = tsel != 0 ? c0 : 24'hFFFFFF;
    for (int i = 0; i < n; i++) begin
      if (cnt == c0) flg |= 2;
      if (cnt == c1) flg |= 4;
      if (cnt == tp) begin flg |= 1; cnt = 0; end
      else cnt++;
    end
  endtask

  task automatic prep(input int c0, input int c1);
    wr(0, 0); wr(2, 7); wr(4, c0); wr(5, c1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] v, x0;
    int ec, ef;
    #12 rst_n = 1;
    @(negedge clk);
    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk("R1 register reset", 32'(v), 0);
    end
    chk("R1 count reset", 32'(count), 0);
    chk("R1 irq reset", 32'(irq), 0);

    // vector table: R2 R4 R5
    for (int i = 0; i < NV; i++) begin
      prep(V_C0[i], V_C1[i]);
      wr(0, V_TOP[i] != 0 ? 5 : 1);
      ticks(V_N[i]);
      model(V_TOP[i], V_C0[i], V_C1[i], V_N[i], ec, ef);
      chk("R2 R4 count vector", 32'(count), 32'(ec));
      rd(2, v);
      chk("R5 R4 flags vector", 32'(v), 32'(ef));
    end

    // R2 restart from zero
    prep(50, 50);
    wr(0, 1);
    ticks(6);
    chk("R2 running", 32'(count), 6);
    wr(0, 0);
    ticks(1);
    chk("R2 disabled holds zero", 32'(count), 0);
    wr(0, 1);
    ticks(3);
    chk("R2 restart from zero", 32'(count), 3);

    // R6 debug halt
    prep(50, 50);
    dbg_halt = 1;
    wr(0, 1);
    ticks(10);
    chk("R6 halted without debug-run", 32'(count), 0);
    dbg_halt = 0;
    ticks(4);
    chk("R6 resumes after halt", 32'(count), 4);
    wr(0, 3);
    x0 = count;
    dbg_halt = 1;
    ticks(5);
    chk("R6 debug-run keeps counting", 32'(count), 32'(x0) + 5);
    dbg_halt = 0;

    // R3 natural wrap on the narrow instance
    prep(24'h300, 24'h400);
    wr(0, 1);
    ticks(255);
    chk("R3 just below wrap", 32'(s_count), 255);
    rd_addr = 2; #0.3;
    chk("R3 no overflow yet", 32'(s_rd_data[0]), 0);
    ticks(1);
    chk("R3 wrapped to zero", 32'(s_count), 0);
    rd_addr = 2; #0.3;
    chk("R3 overflow flag", 32'(s_rd_data[0]), 1);

    // R9 unused compare slots
    prep(11, 22);
    wr(6, 33); wr(7, 44);
    rd(6, v); chk("R9 slot 2 reads zero", 32'(v), 0);
    rd(7, v); chk("R9 slot 3 reads zero", 32'(v), 0);
    rd(4, v); chk("R9 compare 0 untouched", 32'(v), 11);
    rd(5, v); chk("R9 compare 1 untouched", 32'(v), 22);

    // R10 freeze staging
    prep(40, 40);
    wr(3, 1);
    wr(4, 2);
    wr(0, 5);
    ticks(4);
    chk("R10 frozen control not applied", 32'(count), 0);
    rd(0, v); chk("R10 staged control readback", 32'(v), 5);
    rd(4, v); chk("R10 staged compare readback", 32'(v), 2);
    wr(3, 0);
    ticks(4);
    chk("R10 applied on release", 32'(count), 1);
    rd(2, v); chk("R10 top from staged compare", 32'(v), 3);

    // R7 R8 flag clear and interrupt mask
    prep(2, 3);
    wr(0, 1);
    ticks(5);
    wr(0, 0);
    rd(2, v); chk("R5 both compare flags", 32'(v), 6);
    wr(1, 0); chk("R8 all masked", 32'(irq), 0);
    wr(1, 1); chk("R8 only clear flag enabled", 32'(irq), 0);
    wr(1, 2); chk("R8 enabled flag raises irq", 32'(irq), 1);
    wr(2, 2);
    rd(2, v); chk("R7 single flag cleared", 32'(v), 4);
    chk("R8 irq drops after clear", 32'(irq), 0);
    wr(1, 4); chk("R8 remaining flag enabled", 32'(irq), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule